// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in packed BCD. A fast prescaled strobe, `sub_tick`, feeds a sub-second divider. Every `TICKS_PER_SEC` strobes the divider produces one second, and that second moves seconds, minutes, 24-hour hours, day of week, day of month, month and year forward. A century flag can toggle when the year rolls over. Month lengths and leap years are handled inside the block.

The block holds two copies of its registers. The running copy is the one the counter updates and the write port modifies. The user copy is what `rd_data` shows. While `freeze` is low, the user copy reloads from the running copy on every cycle in one parallel transfer. While `freeze` is high, a reader sees a consistent snapshot, and the running copy keeps counting underneath it. The write port and the read port are plain strobed register ports. There is no stream interface, so there is no back-pressure: a write is taken in the cycle `wr_en` is high, and a read is combinational from `rd_addr`.

Top module: `bcd_timekeeper`

## Requirements
- R1: Seconds (address 0, bits 6:0) and minutes (address 1, bits 6:0) count 00 to 59 in packed BCD, tens in bits 6:4 and units in bits 3:0. Each one carries into the next field when it wraps from 59 to 00.
- R2: Hours (address 2, bits 5:0) count 00 to 23 in BCD. Day of week (address 3, bits 2:0) counts 1 to 7 and goes from 7 back to 1. It advances when the hours wrap from 23 to 00.
- R3: Date (address 4, bits 5:0) counts from 01 to the month length, then returns to 01 and advances the month (address 5, bits 4:0, 01 to 12). The month advances the year (address 6, 00 to 99). Months 04, 06, 09 and 11 have 30 days and the other months except 02 have 31. Month 02 has 29 days when the year is divisible by four, including year 00, and 28 days otherwise.
- R4: Address 2 bit 7 is the century enable and bit 6 is the century flag. When the year wraps from 99 to 00, the flag inverts if the enable is 1 and holds if the enable is 0.
- R5: Address 0 bit 7 is the stop bit and is also driven on `stop_bit`. While it is 1, no second is counted and the oscillator-fail flag is set on the next cycle.
- R6: The oscillator-fail flag is address 1 bit 7 and is also driven on `osc_fail`. It is 1 after reset. It stays 1 until a write to address 1 with bit 7 equal to 0, and the stop bit being 1 overrides that write.
- R7: A write to any address from 0 to 6 clears the sub-second divider. The next second is then counted only after a full `TICKS_PER_SEC` more strobes.
- R8: While `freeze` is high, the user copy seen on `rd_data` does not change. In the first cycle after `freeze` is low at a clock edge, the user copy equals the running copy.
- R9: Seconds that elapse while `freeze` is high still advance the running copy, so after release the user copy shows every elapsed second.
- R10: A field written with a value at or above its maximum wraps to its minimum on the next increment and carries into the next field. A units digit of 9 or more rolls to 0 and increments the tens digit.
- R11: Reset gives 00 at addresses 0, 2 and 6, 80h at address 1, and 01h at addresses 3, 4 and 5. Address 7 always reads 00h, and writes to it change nothing. A written value appears on `rd_data` one clock after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_tick | input | 1 | One-cycle prescaled strobe feeding the sub-second divider |
| freeze | input | 1 | Holds the user copy while high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | User-copy byte at `rd_addr` |
| stop_bit | output | 1 | Current stop bit of the running copy |
| osc_fail | output | 1 | Current oscillator-fail flag of the running copy |

## Verification
The hardest case to reach from the ports is a second that arrives while the user copy is frozen. To show that no time is lost, the count must advance unseen and then appear in a single catch-up transfer. The bench holds `freeze` for two full seconds of strobes, confirms that the old value is still read, then releases `freeze` and reads two elapsed seconds one cycle later. Deep carry chains are reached by writing values just before a boundary, such as 23:59:59 on the last day of a month or year, and letting one second pass. The divider clear is exposed by writing between two strobes, so that an uncleared divider would have produced a second one strobe early.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef struct packed {
    logic       stop;
    logic [6:0] sec;
    logic       osc_f;
    logic [6:0] min;
    logic       ceb;
    logic       cb;
    logic [5:0] hr;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] yr;
  } tk_regs_t;

  localparam tk_regs_t TK_RESET = '{
    stop: 1'b0, sec: 7'h00, osc_f: 1'b1, min: 7'h00, ceb: 1'b0, cb: 1'b0,
    hr: 6'h00, dow: 3'd1, date: 6'h01, mon: 5'h01, yr: 8'h00
  };

  // true when a BCD field must return to its minimum on the next increment
  function automatic logic bcd_wrap(input logic [7:0] v, input logic [7:0] lim);
    return v >= lim;
  endfunction

  // next BCD value of a field; out-of-range values fall back to lo
  function automatic logic [7:0] bcd_next(input logic [7:0] v, input logic [7:0] lim,
                                          input logic [7:0] lo);
    if (v >= lim) return lo;
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

endpackage

// File: rtl/tk_second_divider.sv
module tk_second_divider #(
  parameter int TICKS_PER_SEC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sub_tick,
  input  logic halt,
  input  logic clear,
  output logic sec_pulse
);
  localparam int DIV_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(TICKS_PER_SEC - 1);

  logic [DIV_W-1:0] cnt_q;
  logic             step;

  assign step      = sub_tick && !halt && !clear;
  assign sec_pulse = step && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt_q <= '0;
    else if (step) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/tk_date_advance.sv
module tk_date_advance
  import tk_pkg::*;
(
  input  tk_regs_t cur,
  output tk_regs_t nxt
);
  logic       leap;
  logic [7:0] mlen;
  logic c_s, c_m, c_h, c_d, c_mo, c_y;

  // year divisible by four: 2*tens + units == 0 mod 4
  assign leap = (2'({cur.yr[4], 1'b0}) + cur.yr[1:0]) == 2'd0;

  always_comb begin
    case ({3'b000, cur.mon})
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  assign c_s  = bcd_wrap({1'b0, cur.sec}, 8'h59);
  assign c_m  = bcd_wrap({1'b0, cur.min}, 8'h59);
  assign c_h  = bcd_wrap({2'b00, cur.hr}, 8'h23);
  assign c_d  = bcd_wrap({2'b00, cur.date}, mlen);
  assign c_mo = bcd_wrap({3'b000, cur.mon}, 8'h12);
  assign c_y  = bcd_wrap(cur.yr, 8'h99);

  always_comb begin
    nxt     = cur;
    nxt.sec = 7'(bcd_next({1'b0, cur.sec}, 8'h59, 8'h00));
    if (c_s) begin
      nxt.min = 7'(bcd_next({1'b0, cur.min}, 8'h59, 8'h00));
      if (c_m) begin
        nxt.hr = 6'(bcd_next({2'b00, cur.hr}, 8'h23, 8'h00));
        if (c_h) begin
          nxt.dow  = 3'(bcd_next({5'b00000, cur.dow}, 8'h07, 8'h01));
          nxt.date = 6'(bcd_next({2'b00, cur.date}, mlen, 8'h01));
          if (c_d) begin
            nxt.mon = 5'(bcd_next({3'b000, cur.mon}, 8'h12, 8'h01));
            if (c_mo) begin
              nxt.yr = bcd_next(cur.yr, 8'h99, 8'h00);
              if (c_y && cur.ceb) nxt.cb = ~cur.cb;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/tk_user_copy.sv
module tk_user_copy
  import tk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     freeze,
  input  tk_regs_t run,
  output tk_regs_t user
);
  always_ff @(posedge clk) begin
    if (!rst_n) user <= TK_RESET;
    else if (!freeze) user <= run;
  end
endmodule

// File: rtl/bcd_timekeeper.sv
module bcd_timekeeper
  import tk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_tick,
  input  logic       freeze,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       stop_bit,
  output logic       osc_fail
);
  localparam logic [2:0] LAST_CLOCK_ADDR = 3'd6;

  tk_regs_t run_q, run_nxt, adv, user_q;
  logic     wr_hit, sec_pulse;

  assign wr_hit = wr_en && (wr_addr <= LAST_CLOCK_ADDR);

  tk_second_divider #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick),
    .halt(run_q.stop), .clear(wr_hit), .sec_pulse(sec_pulse)
  );

  tk_date_advance u_adv (.cur(run_q), .nxt(adv));

  always_comb begin
    run_nxt = sec_pulse ? adv : run_q;
    if (wr_hit) begin
      case (wr_addr)
        3'd0: begin run_nxt.stop = wr_data[7]; run_nxt.sec = wr_data[6:0]; end
        3'd1: begin run_nxt.osc_f = wr_data[7]; run_nxt.min = wr_data[6:0]; end
        3'd2: begin
          run_nxt.ceb = wr_data[7];
          run_nxt.cb  = wr_data[6];
          run_nxt.hr  = wr_data[5:0];
        end
        3'd3:    run_nxt.dow  = wr_data[2:0];
        3'd4:    run_nxt.date = wr_data[5:0];
        3'd5:    run_nxt.mon  = wr_data[4:0];
        default: run_nxt.yr   = wr_data;
      endcase
    end
    if (run_q.stop) run_nxt.osc_f = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= TK_RESET;
    else run_q <= run_nxt;
  end

  tk_user_copy u_copy (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .run(run_q), .user(user_q)
  );

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = {user_q.stop, user_q.sec};
      3'd1:    rd_data = {user_q.osc_f, user_q.min};
      3'd2:    rd_data = {user_q.ceb, user_q.cb, user_q.hr};
      3'd3:    rd_data = {5'b00000, user_q.dow};
      3'd4:    rd_data = {2'b00, user_q.date};
      3'd5:    rd_data = {3'b000, user_q.mon};
      3'd6:    rd_data = user_q.yr;
      default: rd_data = 8'h00;
    endcase
  end

  assign stop_bit = run_q.stop;
  assign osc_fail = run_q.osc_f;
endmodule

// File: rtl/tk_checker.sv
module tk_checker
  import tk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       freeze,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic       wr_d7,
  input logic       stop_bit,
  input logic       osc_fail,
  input tk_regs_t   run,
  input tk_regs_t   user
);
  assert_hold_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(user));

  assert_catch_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> (user == $past(run)));

  assert_stop_sets_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_bit |=> osc_fail);

  assert_stop_halts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_bit && !wr_en) |=> ($stable(run.sec) && $stable(run.min)));

  assert_fail_cleared_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(osc_fail) |-> $past(wr_en && (wr_addr == 3'd1) && !wr_d7));
endmodule

bind bcd_timekeeper tk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .freeze(freeze), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_d7(wr_data[7]), .stop_bit(stop_bit), .osc_fail(osc_fail),
  .run(run_q), .user(user_q)
);

// File: tb/sim_bcd_timekeeper.sv
`timescale 1ns/1ps
module sim_bcd_timekeeper;
  localparam int TPS = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sub_tick = 1'b0;
  logic       freeze = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       stop_bit, osc_fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bcd_timekeeper #(.TICKS_PER_SEC(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .freeze(freeze),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .stop_bit(stop_bit), .osc_fail(osc_fail)
  );

  always #10 clk = ~clk;

  // input: yr mon date hr min sec ; expected: dow yr mon date hr min sec
  localparam logic [103:0] VEC [13] = '{
    {48'h240315_102030, 56'h07_240315_102031},  // R1 seconds
    {48'h240315_102059, 56'h07_240315_102100},  // R1 minute carry
    {48'h240315_105959, 56'h07_240315_110000},  // R1 hour carry
    {48'h240315_235959, 56'h01_240316_000000},  // R2 midnight, dow 7 to 1
    {48'h230228_235959, 56'h01_230301_000000},  // R3 february, not leap
    {48'h240228_235959, 56'h01_240229_000000},  // R3 leap year
    {48'h240229_235959, 56'h01_240301_000000},  // R3 leap end
    {48'h240430_235959, 56'h01_240501_000000},  // R3 30-day month
    {48'h240530_235959, 56'h01_240531_000000},  // R3 31-day month
    {48'h241231_235959, 56'h01_250101_000000},  // R3 year carry
    {48'h000228_235959, 56'h01_000229_000000},  // R3 year 00 is leap
    {48'h240315_10205A, 56'h07_240315_102100},  // R10 seconds above range
    {48'h240315_10200A, 56'h07_240315_102010}   // R10 units digit above 9
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse_sub(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 sub_tick = 1'b1;
      @(posedge clk); #1 sub_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic set_all(input logic [7:0] y, mo, dt, h, mi, s);
    wr(3'd6, y); wr(3'd5, mo); wr(3'd4, dt); wr(3'd3, 8'h07);
    wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
  endtask

  task automatic rd_all(output logic [55:0] v);
    logic [7:0] b [7];
    for (int i = 0; i < 7; i++) rd(3'(i), b[i]);
    v = {b[3], b[6], b[5], b[4], b[2], b[1], b[0]};
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  b;
    logic [55:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R11 reset map, R6 fail flag set, R5 stop clear
    rd_all(v);
    chk("R11 reset values", 64'(v), 64'h01_000101_008000);
    chk("R6 osc_fail after reset", 64'(osc_fail), 64'd1);
    chk("R5 stop_bit after reset", 64'(stop_bit), 64'd0);
    wr(3'd7, 8'hFF);
    settle();
    rd(3'd7, b);
    chk("R11 address 7 reads zero", 64'(b), 64'h00);
    rd_all(v);
    chk("R11 address 7 write ignored", 64'(v), 64'h01_000101_008000);

    for (int k = 0; k < 13; k++) begin
      set_all(VEC[k][103:96], VEC[k][95:88], VEC[k][87:80],
              VEC[k][79:72], VEC[k][71:64], VEC[k][63:56]);
      pulse_sub(TPS);
      settle();
      rd_all(v);
      chk($sformatf("vector %0d (R1 R2 R3 R10)", k), 64'(v), 64'(VEC[k][55:0]));
    end

    // R4 century flag toggles with enable, holds without
    set_all(8'h99, 8'h12, 8'h31, 8'hA3, 8'h59, 8'h59);
    pulse_sub(TPS); settle();
    rd(3'd2, b); chk("R4 century toggles when enabled", 64'(b), 64'hC0);
    rd(3'd6, b); chk("R4 year wraps to 00", 64'(b), 64'h00);
    set_all(8'h99, 8'h12, 8'h31, 8'h63, 8'h59, 8'h59);
    pulse_sub(TPS); settle();
    rd(3'd2, b); chk("R4 century holds when disabled", 64'(b), 64'h40);

    // R5 stop halts and sets fail; R6 flag held until written
    wr(3'd1, 8'h05);
    wr(3'd0, 8'h90);
    settle();
    chk("R5 stop_bit set", 64'(stop_bit), 64'd1);
    chk("R5 stop sets osc_fail", 64'(osc_fail), 64'd1);
    pulse_sub(2 * TPS); settle();
    rd(3'd0, b); chk("R5 seconds halted", 64'(b), 64'h90);
    wr(3'd0, 8'h10);
    settle();
    chk("R6 osc_fail held after stop clear", 64'(osc_fail), 64'd1);
    pulse_sub(TPS); settle();
    rd(3'd0, b); chk("R5 counting resumes", 64'(b), 64'h11);
    wr(3'd1, 8'h05);
    settle();
    chk("R6 osc_fail cleared by write", 64'(osc_fail), 64'd0);

    // R7 any clock write clears the divider
    wr(3'd0, 8'h00);
    pulse_sub(1);
    wr(3'd1, 8'h05);
    pulse_sub(1); settle();
    rd(3'd0, b); chk("R7 divider cleared, no early second", 64'(b), 64'h00);
    pulse_sub(1); settle();
    rd(3'd0, b); chk("R7 second after full count", 64'(b), 64'h01);

    // R8 freeze holds user copy, R9 running copy keeps counting
    wr(3'd0, 8'h10);
    settle();
    freeze = 1'b1;
    pulse_sub(2 * TPS); settle();
    rd(3'd0, b); chk("R8 user copy frozen", 64'(b), 64'h10);
    freeze = 1'b0;
    @(posedge clk); #1;
    rd(3'd0, b); chk("R9 catch-up shows elapsed seconds", 64'(b), 64'h12);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule